// File: doc/BRIEF.md
# Accumulator Arithmetic/Logic Unit with Condition Flags

This block computes the next accumulator value and the next condition flags for an 8-bit, accumulator-based processor. The datapath is combinational. It takes the accumulator, a second operand, the current flag byte and a 4-bit operation code. It returns a result byte, a write-enable for that result, and the next flag byte.

The next flag byte is also captured in a register whenever `op_valid` is high. The surrounding core can read the flags back from that register. Operand fetch, memory traffic, instruction decoding and cycle sequencing all belong to the core.

There are four flags:

- zero
- subtract, which records whether the last arithmetic step was a subtraction
- nibble carry/borrow
- carry/borrow

Each group of operations has its own rule for which flags it writes and which it keeps. The decimal-adjust operation reads the subtract, nibble and carry flags to turn a binary sum or difference back into packed BCD.

Top module: `acc_alu`

## Requirements
- R1: Flag byte layout, used on `flags_in`, `flags_nxt` and `flags_q`: bit 7 = zero (Z), bit 6 = subtract (N), bit 5 = nibble carry (H), bit 4 = carry (C). Bits 3..0 of `flags_nxt` and `flags_q` are always 0, and bits 3..0 of `flags_in` are ignored.
- R2: Op 0 (add) and op 1 (add with carry) write `acc_in + opnd_in` (plus C for op 1). Z is set when the 8-bit result is 0, N is cleared, H is set on a carry out of bit 3, and C is set on a carry out of bit 7.
- R3: Op 2 (subtract) and op 3 (subtract with borrow) write `acc_in - opnd_in` (minus C for op 3). N is set. C is set when the subtrahend, including the borrow-in, exceeds `acc_in`. H is set when the low nibble of the subtrahend, including the borrow-in, exceeds the low nibble of `acc_in`. Z is set when the result is 0.
- R4: Op 4 (compare) produces the same flags as op 2 and holds `res_we` low.
- R5: Op 5 (AND) writes the bitwise AND, sets Z from the result, and forces N=0, H=1, C=0.
- R6: Op 6 (OR) and op 7 (XOR) write the bitwise result, set Z from it, and force N=0, H=0, C=0.
- R7: Op 8 (increment) and op 9 (decrement) write `acc_in` ± 1 and set Z from the result. H is a carry out of bit 3 for increment and a borrow into bit 4 for decrement. N is 0 for increment and 1 for decrement. C keeps its input value.
- R8: Op 10 (complement) writes `~acc_in`, sets N=1 and H=1, and keeps Z and C.
- R9: Op 11 (set carry) sets C=1, N=0, H=0. Op 12 (complement carry) inverts C and sets N=0, H=0. Both keep Z and write the accumulator back unchanged.
- R10: Op 13 (decimal adjust) with N=0: add 0x06 if H is set or the low nibble exceeds 9; add 0x60 and set C if C is set or the accumulator exceeds 0x99. Otherwise C keeps its value.
- R11: Op 13 with N=1: subtract 0x06 if H is set and subtract 0x60 if C is set. C and N are kept. For either value of N, H is cleared and Z is taken from the adjusted value.
- R12: Ops 14 and 15 hold `res_we` low and pass the flags through unchanged.
- R13: `flags_q` resets to 0x00, loads `flags_nxt` on a clock edge where `op_valid` is high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Capture `flags_nxt` into `flags_q` on this edge |
| op_sel | input | 4 | Operation code |
| acc_in | input | 8 | Accumulator value |
| opnd_in | input | 8 | Second operand |
| flags_in | input | 8 | Current flag byte |
| res | output | 8 | Result byte |
| res_we | output | 1 | Result should be written to the accumulator |
| flags_nxt | output | 8 | Next flag byte (combinational) |
| flags_q | output | 8 | Registered flag byte |

## Verification
Arithmetic is driven with operand pairs chosen to separate the nibble carry from the full carry: a low-nibble overflow without a bit-7 carry, and the reverse. It is also driven with pairs whose sum or difference wraps to exactly zero, which is where the zero flag has to be taken from the 8-bit value and not the 9-bit one.

Subtraction and compare use equal operands, operands that differ only in the high nibble, and a borrow-in that tips an equal pair into a borrow. Decimal adjust follows real BCD additions and subtractions, including ones that cross 99. Each flag-only operation is given opposing input flags, so that a kept flag is distinguishable from a forced one.

// File: rtl/acc_alu.sv
module acc_alu (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_valid,
  input  logic [3:0] op_sel,
  input  logic [7:0] acc_in,
  input  logic [7:0] opnd_in,
  input  logic [7:0] flags_in,
  output logic [7:0] res,
  output logic       res_we,
  output logic [7:0] flags_nxt,
  output logic [7:0] flags_q
);
  localparam logic [3:0] OP_ADD = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBC = 4'd3;
  localparam logic [3:0] OP_CMP = 4'd4,  OP_AND = 4'd5,  OP_OR  = 4'd6,  OP_XOR = 4'd7;
  localparam logic [3:0] OP_INC = 4'd8,  OP_DEC = 4'd9,  OP_CPL = 4'd10, OP_SCF = 4'd11;
  localparam logic [3:0] OP_CCF = 4'd12, OP_DAA = 4'd13;

  logic fz, fn, fh, fc;
  assign {fz, fn, fh, fc} = flags_in[7:4];

  logic       cin;
  logic [8:0] sum9, dif9;
  logic [4:0] sum5;
  logic       bor4, bor8;
  assign cin  = (op_sel == OP_ADC || op_sel == OP_SBC) ? fc : 1'b0;
  assign sum9 = {1'b0, acc_in} + {1'b0, opnd_in} + {8'd0, cin};
  assign sum5 = {1'b0, acc_in[3:0]} + {1'b0, opnd_in[3:0]} + {4'd0, cin};
  assign dif9 = {1'b0, acc_in} - {1'b0, opnd_in} - {8'd0, cin};
  assign bor8 = ({1'b0, opnd_in} + {8'd0, cin}) > {1'b0, acc_in};
  assign bor4 = ({1'b0, opnd_in[3:0]} + {4'd0, cin}) > {1'b0, acc_in[3:0]};

  logic [7:0] daa_adj;
  logic       daa_c;
  always_comb begin
    daa_adj = 8'h00;
    daa_c   = fc;
    if (!fn) begin
      if (fh || acc_in[3:0] > 4'd9) daa_adj[3:0] = 4'h6;
      if (fc || acc_in > 8'h99) begin
        daa_adj[7:4] = 4'h6;
        daa_c        = 1'b1;
      end
    end else begin
      if (fh) daa_adj[3:0] = 4'h6;
      if (fc) daa_adj[7:4] = 4'h6;
    end
  end

  logic n_n, n_h, n_c;
  always_comb begin
    res    = acc_in;
    res_we = 1'b1;
    n_n = fn; n_h = fh; n_c = fc;
    case (op_sel)
      OP_ADD, OP_ADC: begin
        res = sum9[7:0]; n_n = 1'b0; n_h = sum5[4]; n_c = sum9[8];
      end
      OP_SUB, OP_SBC, OP_CMP: begin
        res = dif9[7:0]; n_n = 1'b1; n_h = bor4; n_c = bor8;
        if (op_sel == OP_CMP) res_we = 1'b0;
      end
      OP_AND: begin res = acc_in & opnd_in; n_n = 1'b0; n_h = 1'b1; n_c = 1'b0; end
      OP_OR:  begin res = acc_in | opnd_in; n_n = 1'b0; n_h = 1'b0; n_c = 1'b0; end
      OP_XOR: begin res = acc_in ^ opnd_in; n_n = 1'b0; n_h = 1'b0; n_c = 1'b0; end
      OP_INC: begin res = acc_in + 8'd1; n_n = 1'b0; n_h = (acc_in[3:0] == 4'hF); end
      OP_DEC: begin res = acc_in - 8'd1; n_n = 1'b1; n_h = (acc_in[3:0] == 4'h0); end
      OP_CPL: begin res = ~acc_in; n_n = 1'b1; n_h = 1'b1; end
      OP_SCF: begin n_n = 1'b0; n_h = 1'b0; n_c = 1'b1; end
      OP_CCF: begin n_n = 1'b0; n_h = 1'b0; n_c = ~fc; end
      OP_DAA: begin
        res = fn ? acc_in - daa_adj : acc_in + daa_adj;
        n_h = 1'b0; n_c = daa_c;
      end
      default: res_we = 1'b0;
    endcase
  end

  logic n_z;
  always_comb begin
    case (op_sel)
      OP_CPL, OP_SCF, OP_CCF, 4'd14, 4'd15: n_z = fz;
      default:                              n_z = (res == 8'h00);
    endcase
  end

  assign flags_nxt = {n_z, n_n, n_h, n_c, 4'b0000};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        flags_q <= 8'h00;
    else if (op_valid) flags_q <= flags_nxt;

  p_low_nibble_r1: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q[3:0] == 4'h0);
  p_cmp_nowrite_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel == OP_CMP |-> !res_we);
  p_and_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_sel == OP_AND |=> flags_q[6:4] == 3'b010);
  p_incdec_keep_c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op_sel == OP_INC || op_sel == OP_DEC) |=> flags_q[4] == $past(flags_in[4]));
  p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(flags_q));
endmodule

// File: tb/acc_alu_tb.sv
module acc_alu_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [3:0] op_sel = 4'd0;
  logic [7:0] acc_in = 8'd0, opnd_in = 8'd0, flags_in = 8'd0;
  logic [7:0] res, flags_nxt, flags_q;
  logic       res_we;

  always #2.5 clk = ~clk;

  acc_alu u_dut (.clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
                 .acc_in(acc_in), .opnd_in(opnd_in), .flags_in(flags_in),
                 .res(res), .res_we(res_we), .flags_nxt(flags_nxt), .flags_q(flags_q));

  typedef struct { int req; logic [7:0] r; logic we; logic [7:0] fq; } item_t;
  item_t sb[$];
  int total = 0, bad = 0;
  logic [7:0] model_q = 8'h00;
  bit drv_done = 0;

  function automatic logic [16:0] model(input logic [3:0] op, input logic [7:0] a,
                                        input logic [7:0] b, input logic [7:0] f);
    logic z, n, h, c, we, kz;
    logic [7:0] r;
    int s, t;
    z = f[7]; n = f[6]; h = f[5]; c = f[4];
    r = a; we = 1; kz = 0;
    case (op)
      0, 1: begin
        s = a + b + ((op == 1 && c) ? 1 : 0);
        t = (a & 15) + (b & 15) + ((op == 1 && c) ? 1 : 0);
        r = s[7:0]; n = 0; h = t > 15; c = s > 255;
      end
      2, 3, 4: begin
        s = b + ((op == 3 && c) ? 1 : 0);
        t = (b & 15) + ((op == 3 && c) ? 1 : 0);
        r = 8'(int'(a) - s); n = 1; h = t > (a & 15); c = s > a; we = (op != 4);
      end
      5: begin r = a & b; n = 0; h = 1; c = 0; end
      6: begin r = a | b; n = 0; h = 0; c = 0; end
      7: begin r = a ^ b; n = 0; h = 0; c = 0; end
      8: begin r = a + 1; n = 0; h = (a & 15) == 15; end
      9: begin r = a - 1; n = 1; h = (a & 15) == 0; end
      10: begin r = ~a; n = 1; h = 1; kz = 1; end
      11: begin n = 0; h = 0; c = 1; kz = 1; end
      12: begin n = 0; h = 0; c = ~c; kz = 1; end
      13: begin
        s = 0;
        if (!n) begin
          if (h || (a & 15) > 9) s += 6;
          if (c || a > 153) begin s += 96; c = 1; end
          r = 8'(int'(a) + s);
        end else begin
          if (h) s += 6;
          if (c) s += 96;
          r = 8'(int'(a) - s);
        end
        h = 0;
      end
      default: begin we = 0; kz = 1; end
    endcase
    if (!kz) z = (r == 0);
    return {we, r, z, n, h, c, 4'b0000};
  endfunction

  task automatic drive(input int req, input logic vld, input logic [3:0] op,
                       input logic [7:0] a, input logic [7:0] b, input logic [7:0] f);
    logic [16:0] m;
    item_t it;
    @(negedge clk);
    op_valid = vld; op_sel = op; acc_in = a; opnd_in = b; flags_in = f;
    m = model(op, a, b, f);
    if (vld) model_q = m[7:0];
    it.req = req; it.we = m[16]; it.r = m[15:8]; it.fq = model_q;
    sb.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(posedge clk); #2;
      if (sb.size() > 0) begin
        it = sb.pop_front();
        total++;
        if (res !== it.r || res_we !== it.we || flags_q !== it.fq) begin
          bad++;
          $display("FAIL R%0d op=%0d: got res=%h we=%b fq=%h, exp res=%h we=%b fq=%h",
                   it.req, op_sel, res, res_we, flags_q, it.r, it.we, it.fq);
        end
      end
    end
  end

  initial begin : watchdog
    #200000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (flags_q !== 8'h00) begin
      bad++; $display("FAIL R13 reset flags got=%h exp=00", flags_q);
    end
    rst_n = 1'b1;
    // R2 add / add with carry
    drive(2, 1, 0, 8'h0F, 8'h01, 8'h00);
    drive(2, 1, 0, 8'hF0, 8'h10, 8'h00);
    drive(2, 1, 0, 8'h80, 8'h80, 8'h00);
    drive(2, 1, 1, 8'hFF, 8'h00, 8'h10);
    drive(2, 1, 1, 8'h12, 8'h34, 8'h10);
    // R3 subtract / subtract with borrow
    drive(3, 1, 2, 8'h42, 8'h42, 8'h00);
    drive(3, 1, 2, 8'h10, 8'h01, 8'h00);
    drive(3, 1, 2, 8'h20, 8'h30, 8'h00);
    drive(3, 1, 3, 8'h42, 8'h42, 8'h10);
    drive(3, 1, 3, 8'h50, 8'h10, 8'h10);
    // R4 compare
    drive(4, 1, 4, 8'h33, 8'h33, 8'h00);
    drive(4, 1, 4, 8'h05, 8'h90, 8'h00);
    // R5 AND
    drive(5, 1, 5, 8'hF0, 8'h0F, 8'h50);
    drive(5, 1, 5, 8'hAA, 8'h8F, 8'h00);
    // R6 OR / XOR
    drive(6, 1, 6, 8'h00, 8'h00, 8'hF0);
    drive(6, 1, 7, 8'h5A, 8'h5A, 8'h70);
    drive(6, 1, 7, 8'h5A, 8'hA5, 8'h30);
    // R7 increment / decrement
    drive(7, 1, 8, 8'hFF, 8'h00, 8'h10);
    drive(7, 1, 8, 8'h0F, 8'h00, 8'h00);
    drive(7, 1, 9, 8'h01, 8'h00, 8'h10);
    drive(7, 1, 9, 8'h10, 8'h00, 8'h00);
    // R8 complement
    drive(8, 1, 10, 8'h3C, 8'h00, 8'h90);
    drive(8, 1, 10, 8'hFF, 8'h00, 8'h00);
    // R9 set / complement carry
    drive(9, 1, 11, 8'h77, 8'h00, 8'hE0);
    drive(9, 1, 12, 8'h77, 8'h00, 8'hF0);
    drive(9, 1, 12, 8'h77, 8'h00, 8'h60);
    // R10 decimal adjust after add (15+27, 99+01, 90+90)
    drive(10, 1, 13, 8'h3C, 8'h00, 8'h00);
    drive(10, 1, 13, 8'h9A, 8'h00, 8'h00);
    drive(10, 1, 13, 8'h20, 8'h00, 8'h10);
    drive(10, 1, 13, 8'h41, 8'h00, 8'h20);
    drive(10, 1, 13, 8'h00, 8'h00, 8'h30);
    // R11 decimal adjust after subtract (42-15, 10-20)
    drive(11, 1, 13, 8'h2D, 8'h00, 8'h60);
    drive(11, 1, 13, 8'hF0, 8'h00, 8'h50);
    drive(11, 1, 13, 8'h06, 8'h00, 8'h60);
    // R12 unused codes
    drive(12, 1, 14, 8'h12, 8'h34, 8'hB0);
    drive(12, 1, 15, 8'h00, 8'h00, 8'h40);
    // R1 low nibble of flags_in ignored
    drive(1, 1, 12, 8'h00, 8'h00, 8'h0F);
    drive(1, 1, 15, 8'h00, 8'h00, 8'hFF);
    // R13 hold when op_valid is low
    drive(13, 0, 5, 8'h00, 8'h00, 8'h00);
    drive(13, 0, 11, 8'h00, 8'h00, 8'h00);
    drive(13, 1, 0, 8'h01, 8'h01, 8'h00);
    for (int i = 0; i < 40; i++)
      drive(2, 1, 4'(i % 14), 8'(i * 37 + 5), 8'(i * 91 + 3), 8'(i * 16));
    @(negedge clk); op_valid = 1'b0;
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule